// File: doc/BRIEF.md
# Framebuffer Pixel Unpacker

This block sits between a framebuffer fetch engine and a palette or colour pipeline. It takes one 32-bit framebuffer word at a time over a valid/ready handshake. It then emits the pixels packed in that word, one per clock, in the order set by the byte-order and pixel-order controls. Depths of 1, 2, 4 and 8 bits produce an 8-bit palette index. Depths of 12, 16 and 32 bits produce a direct colour, widened to 8 bits per channel.

A 3-bit mode code selects the depth, and a red/blue swap control reorders the colour channels. In the base variant, a 2-bit board-level mux input decides how the plain 16-bit mode is laid out. The extended variant ignores the mux input and decodes the 16-bit layouts straight from the mode code. The block also converts the line width in pixels into the number of bytes per line for the current mode.

Top module: `fb_pixel_unpack`

## Requirements
- R1: After reset, `word_ready_o` is 1, `pix_valid_o` is 0, and both pixel outputs are 0.
- R2: A word is taken on a clock edge where `word_valid_i` and `word_ready_o` are both 1. Its pixels appear on consecutive cycles, starting in the cycle after that edge. `word_ready_o` stays 0 until the last pixel has been shown, and it rises in the cycle after the last pixel.
- R3: Mode codes map to depths and pixels per word as follows: 0 is 1 bit (32 pixels), 1 is 2 bits (16), 2 is 4 bits (8), 3 is 8 bits (4), 4 is 16 bits (2), 5 is 32 bits (1), 6 is 16-bit 565 (2) and 7 is 12 bits in a 16-bit slot (2).
- R4: With both order controls at 0, pixel k is taken from bits [k*d +: d] of the word, where d is the slot width. The lowest pixel is emitted first.
- R5: With `be_byte_i` at 1, the word is read fully big-endian. Bits [7:0] form the first byte. Within each byte, pixels are taken from the most significant bits first. For 16-bit slots, the byte in bits [7:0] is the high byte of the pixel, and for 32-bit pixels the whole word is byte-reversed.
- R6: With `be_pix_i` at 1 and `be_byte_i` at 0, bytes are taken low byte first, and pixels narrower than 8 bits are taken from the most significant bits of each byte first. This control has no effect at 8 bits or more. `be_byte_i` wins when both controls are set.
- R7: Modes 0 to 3 set `pix_is_index_o` to 1, drive the index zero-extended on `pix_index_o`, and drive `pix_rgb_o` as 0.
- R8: Colour modes set `pix_is_index_o` to 0, drive `pix_index_o` as 0, and drive `pix_rgb_o` as {R,G,B}, with R in bits [23:16]. Channel widths are widened by repeating their top bits. The layouts are:
  - 5551: R [4:0], G [9:5], B [14:10].
  - 565: R [4:0], G [10:5], B [15:11].
  - 444: R [3:0], G [7:4], B [11:8].
  - 32-bit: R [7:0], G [15:8], B [23:16].
- R9: `bgr_i` at 1 swaps the red and blue output channels.
- R10: In the base variant, mode 4 depends on `mux_i`. A value of 1 gives 5551 and honours `bgr_i`. A value of 3 gives 565 with red and blue always swapped. Values 0 and 2 give 565 and honour `bgr_i`. Mode 6 ignores `mux_i`.
- R11: In the extended variant (`EXTENDED`=1), mode 4 is always 5551, and `mux_i` has no effect.
- R12: `line_bytes_o` is computed from `line_width_i` and `mode_i` as follows: width>>3 in mode 0, width>>2 in mode 1, width>>1 in mode 2, width in mode 3, width<<1 in modes 4, 6 and 7, and width<<2 in mode 5.
- R13: The mode, order, swap and mux inputs are captured when a word is taken. Changing them while that word is being emitted does not affect its pixels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 3 | Pixel depth code |
| bgr_i | input | 1 | Swap red and blue |
| be_byte_i | input | 1 | Big-endian byte order |
| be_pix_i | input | 1 | Big-endian pixel order within a byte |
| mux_i | input | 2 | Board mux select for 16-bit layout (base variant) |
| line_width_i | input | WIDTH_W | Line width in pixels |
| line_bytes_o | output | WIDTH_W+2 | Bytes per line for `mode_i` |
| word_i | input | 32 | Framebuffer word |
| word_valid_i | input | 1 | Word available |
| word_ready_o | output | 1 | Block can take a word |
| pix_valid_o | output | 1 | Pixel output valid |
| pix_is_index_o | output | 1 | Pixel is a palette index |
| pix_index_o | output | 8 | Palette index |
| pix_rgb_o | output | 24 | Direct colour {R,G,B} |

## Verification
The assertions rely on three assumptions about the block's inputs:
- `rst_n` is held low through the first edge.
- `mode_i` is valid in the cycle a word is offered.
- `line_width_i` is stable whenever a bytes-per-line check samples it.

The bench drives all inputs only on falling edges and holds every control steady from offer to acceptance. It changes controls during emission only in the capture test. It drops `word_valid_i` right after each acceptance, so no second word is offered while the block is still busy.

// File: rtl/fb_pixel_unpack.sv
module fb_pixel_unpack #(
  parameter bit EXTENDED = 1'b0,
  parameter int WIDTH_W  = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2:0]         mode_i,
  input  logic               bgr_i,
  input  logic               be_byte_i,
  input  logic               be_pix_i,
  input  logic [1:0]         mux_i,
  input  logic [WIDTH_W-1:0] line_width_i,
  output logic [WIDTH_W+1:0] line_bytes_o,
  input  logic [31:0]        word_i,
  input  logic               word_valid_i,
  output logic               word_ready_o,
  output logic               pix_valid_o,
  output logic               pix_is_index_o,
  output logic [7:0]         pix_index_o,
  output logic [23:0]        pix_rgb_o
);
  localparam int LB_W = WIDTH_W + 2;

  typedef enum logic [1:0] {L5551, L565, L444, L888} layout_e;

  logic        busy;
  logic [4:0]  idx, last_idx;
  logic [31:0] word_q, wswap, src, raw;
  logic [2:0]  mode_q;
  logic        bgr_q, beb_q, bep_q;
  logic [1:0]  mux_q;
  logic [5:0]  bits;
  logic [10:0] lin, off;
  logic [7:0]  mask;
  logic        is_idx, swap;
  layout_e     lay;
  logic [7:0]  r, g, b;
  logic [LB_W-1:0] w_ext;

  assign word_ready_o = !busy;
  assign pix_valid_o  = busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      idx    <= '0;
      word_q <= '0;
      mode_q <= '0;
      bgr_q  <= 1'b0;
      beb_q  <= 1'b0;
      bep_q  <= 1'b0;
      mux_q  <= '0;
    end else if (!busy && word_valid_i) begin
      busy   <= 1'b1;
      idx    <= '0;
      word_q <= word_i;
      mode_q <= mode_i;
      bgr_q  <= bgr_i;
      beb_q  <= be_byte_i;
      bep_q  <= be_pix_i;
      mux_q  <= mux_i;
    end else if (busy) begin
      if (idx == last_idx) busy <= 1'b0;
      idx <= idx + 5'd1;
    end
  end

  always_comb begin
    case (mode_q)
      3'd0:    begin bits = 6'd1;  last_idx = 5'd31; mask = 8'h01; end
      3'd1:    begin bits = 6'd2;  last_idx = 5'd15; mask = 8'h03; end
      3'd2:    begin bits = 6'd4;  last_idx = 5'd7;  mask = 8'h0F; end
      3'd3:    begin bits = 6'd8;  last_idx = 5'd3;  mask = 8'hFF; end
      3'd5:    begin bits = 6'd32; last_idx = 5'd0;  mask = 8'h00; end
      default: begin bits = 6'd16; last_idx = 5'd1;  mask = 8'h00; end
    endcase
  end

  assign wswap = {word_q[7:0], word_q[15:8], word_q[23:16], word_q[31:24]};
  assign lin   = 11'(idx) * 11'(bits);

  always_comb begin
    if (beb_q) begin
      src = wswap;
      off = 11'd32 - lin - 11'(bits);
    end else begin
      src = word_q;
      off = (bep_q && bits < 6'd8) ? (lin ^ (11'd8 - 11'(bits))) : lin;
    end
    raw = src >> off[4:0];
  end

  assign is_idx = (mode_q <= 3'd3);

  always_comb begin
    swap = bgr_q;
    case (mode_q)
      3'd4: begin
        if (EXTENDED)           lay = L5551;
        else if (mux_q == 2'd1) lay = L5551;
        else begin
          lay = L565;
          if (mux_q == 2'd3) swap = 1'b1;
        end
      end
      3'd5:    lay = L888;
      3'd7:    lay = L444;
      default: lay = L565;
    endcase
  end

  always_comb begin
    case (lay)
      L5551: begin
        r = {raw[4:0],   raw[4:2]};
        g = {raw[9:5],   raw[9:7]};
        b = {raw[14:10], raw[14:12]};
      end
      L565: begin
        r = {raw[4:0],   raw[4:2]};
        g = {raw[10:5],  raw[10:9]};
        b = {raw[15:11], raw[15:13]};
      end
      L444: begin
        r = {raw[3:0],  raw[3:0]};
        g = {raw[7:4],  raw[7:4]};
        b = {raw[11:8], raw[11:8]};
      end
      default: begin
        r = raw[7:0];
        g = raw[15:8];
        b = raw[23:16];
      end
    endcase
  end

  assign pix_is_index_o = busy && is_idx;
  assign pix_index_o    = (busy && is_idx) ? (raw[7:0] & mask) : 8'h00;
  assign pix_rgb_o      = (busy && !is_idx) ? (swap ? {b, g, r} : {r, g, b}) : 24'h0;

  assign w_ext = LB_W'(line_width_i);
  always_comb begin
    case (mode_i)
      3'd0:    line_bytes_o = w_ext >> 3;
      3'd1:    line_bytes_o = w_ext >> 2;
      3'd2:    line_bytes_o = w_ext >> 1;
      3'd3:    line_bytes_o = w_ext;
      3'd5:    line_bytes_o = w_ext << 2;
      default: line_bytes_o = w_ext << 1;
    endcase
  end
endmodule

// File: rtl/fb_pixel_unpack_chk.sv
module fb_pixel_unpack_chk #(
  parameter int WIDTH_W = 12
) (
  input logic               clk,
  input logic               rst_n,
  input logic [2:0]         mode_i,
  input logic [WIDTH_W-1:0] line_width_i,
  input logic [WIDTH_W+1:0] line_bytes_o,
  input logic               word_valid_i,
  input logic               word_ready_o,
  input logic               pix_valid_o,
  input logic               pix_is_index_o,
  input logic [23:0]        pix_rgb_o
);
  // R2
  accept_to_pixel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid_i && word_ready_o |=> pix_valid_o && !word_ready_o);

  // R2
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pix_valid_o) |-> word_ready_o);

  // R3
  one_cycle_32_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid_i && word_ready_o && mode_i == 3'd5 |=> ##1 word_ready_o);

  // R7
  index_no_rgb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid_o && pix_is_index_o |-> pix_rgb_o == 24'h0);

  // R12
  bytes_8bpp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_i == 3'd3 |-> line_bytes_o == (WIDTH_W+2)'(line_width_i));
endmodule

bind fb_pixel_unpack fb_pixel_unpack_chk #(.WIDTH_W(WIDTH_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .line_width_i(line_width_i),
  .line_bytes_o(line_bytes_o), .word_valid_i(word_valid_i),
  .word_ready_o(word_ready_o), .pix_valid_o(pix_valid_o),
  .pix_is_index_o(pix_is_index_o), .pix_rgb_o(pix_rgb_o)
);

// File: tb/fb_pixel_unpack_tb.sv
module fb_pixel_unpack_tb_top;
  localparam int WW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] mode_i = '0;
  logic bgr_i = 0, be_byte_i = 0, be_pix_i = 0;
  logic [1:0] mux_i = '0;
  logic [WW-1:0] line_width_i = '0;
  logic [31:0] word_i = '0;
  logic word_valid_i = 1'b0;

  logic [WW+1:0] lb_b, lb_x;
  logic rdy_b, rdy_x, pv_b, pv_x, ix_b, ix_x;
  logic [7:0] idx_b, idx_x;
  logic [23:0] rgb_b, rgb_x;

  int total = 0, bad = 0;

  always #4 clk = ~clk;

  fb_pixel_unpack #(.EXTENDED(1'b0), .WIDTH_W(WW)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .bgr_i(bgr_i),
    .be_byte_i(be_byte_i), .be_pix_i(be_pix_i), .mux_i(mux_i),
    .line_width_i(line_width_i), .line_bytes_o(lb_b), .word_i(word_i),
    .word_valid_i(word_valid_i), .word_ready_o(rdy_b), .pix_valid_o(pv_b),
    .pix_is_index_o(ix_b), .pix_index_o(idx_b), .pix_rgb_o(rgb_b));

  fb_pixel_unpack #(.EXTENDED(1'b1), .WIDTH_W(WW)) dut_x_i (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .bgr_i(bgr_i),
    .be_byte_i(be_byte_i), .be_pix_i(be_pix_i), .mux_i(mux_i),
    .line_width_i(line_width_i), .line_bytes_o(lb_x), .word_i(word_i),
    .word_valid_i(word_valid_i), .word_ready_o(rdy_x), .pix_valid_o(pv_x),
    .pix_is_index_o(ix_x), .pix_index_o(idx_x), .pix_rgb_o(rgb_x));

  typedef struct packed {
    logic        ext;
    logic [2:0]  mode;
    logic        bgr, beb, bep;
    logic [1:0]  mux;
    logic [31:0] w;
    logic [4:0]  n;
    logic        isx;
    logic [7:0]  idx;
    logic [23:0] rgb;
  } vec_t;

  localparam logic [31:0] W1 = 32'h8421C35A, W2 = 32'h8000041F,
                          W3 = 32'h00000ABC, W4 = 32'h00332211;
  localparam int NV = 28;
  localparam vec_t V [NV] = '{
    '{1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 2'd0, W1, 5'd1,  1'b1, 8'h01, 24'h0},
    '{1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 2'd0, W1, 5'd31, 1'b1, 8'h01, 24'h0},
    '{1'b0, 3'd1, 1'b0, 1'b0, 1'b0, 2'd0, W1, 5'd2,  1'b1, 8'h01, 24'h0},
    '{1'b0, 3'd1, 1'b0, 1'b0, 1'b0, 2'd0, W1, 5'd15, 1'b1, 8'h02, 24'h0},
    '{1'b0, 3'd2, 1'b0, 1'b0, 1'b0, 2'd0, W1, 5'd0,  1'b1, 8'h0A, 24'h0},
    '{1'b0, 3'd2, 1'b0, 1'b0, 1'b0, 2'd0, W1, 5'd7,  1'b1, 8'h08, 24'h0},
    '{1'b0, 3'd2, 1'b0, 1'b0, 1'b1, 2'd0, W1, 5'd0,  1'b1, 8'h05, 24'h0},
    '{1'b0, 3'd2, 1'b0, 1'b0, 1'b1, 2'd0, W1, 5'd3,  1'b1, 8'h03, 24'h0},
    '{1'b0, 3'd2, 1'b0, 1'b1, 1'b0, 2'd0, W1, 5'd0,  1'b1, 8'h05, 24'h0},
    '{1'b0, 3'd2, 1'b0, 1'b1, 1'b0, 2'd0, W1, 5'd7,  1'b1, 8'h04, 24'h0},
    '{1'b0, 3'd3, 1'b0, 1'b0, 1'b0, 2'd0, W1, 5'd1,  1'b1, 8'hC3, 24'h0},
    '{1'b0, 3'd3, 1'b0, 1'b0, 1'b0, 2'd0, W1, 5'd3,  1'b1, 8'h84, 24'h0},
    '{1'b0, 3'd4, 1'b0, 1'b0, 1'b0, 2'd1, W2, 5'd0,  1'b0, 8'h00, 24'hFF0008},
    '{1'b0, 3'd4, 1'b1, 1'b0, 1'b0, 2'd1, W2, 5'd0,  1'b0, 8'h00, 24'h0800FF},
    '{1'b0, 3'd4, 1'b0, 1'b0, 1'b0, 2'd3, W2, 5'd0,  1'b0, 8'h00, 24'h0082FF},
    '{1'b0, 3'd4, 1'b1, 1'b0, 1'b0, 2'd3, W2, 5'd0,  1'b0, 8'h00, 24'h0082FF},
    '{1'b0, 3'd4, 1'b0, 1'b0, 1'b0, 2'd0, W2, 5'd0,  1'b0, 8'h00, 24'hFF8200},
    '{1'b0, 3'd4, 1'b1, 1'b0, 1'b0, 2'd2, W2, 5'd0,  1'b0, 8'h00, 24'h0082FF},
    '{1'b1, 3'd4, 1'b0, 1'b0, 1'b0, 2'd3, W2, 5'd0,  1'b0, 8'h00, 24'hFF0008},
    '{1'b1, 3'd6, 1'b0, 1'b0, 1'b0, 2'd1, W2, 5'd0,  1'b0, 8'h00, 24'hFF8200},
    '{1'b0, 3'd6, 1'b0, 1'b0, 1'b0, 2'd1, W2, 5'd0,  1'b0, 8'h00, 24'hFF8200},
    '{1'b0, 3'd4, 1'b0, 1'b1, 1'b1, 2'd0, W2, 5'd0,  1'b0, 8'h00, 24'h21E318},
    '{1'b0, 3'd4, 1'b0, 1'b0, 1'b1, 2'd0, W2, 5'd0,  1'b0, 8'h00, 24'hFF8200},
    '{1'b0, 3'd4, 1'b0, 1'b0, 1'b0, 2'd0, W2, 5'd1,  1'b0, 8'h00, 24'h000084},
    '{1'b0, 3'd7, 1'b0, 1'b0, 1'b0, 2'd0, W3, 5'd0,  1'b0, 8'h00, 24'hCCBBAA},
    '{1'b0, 3'd7, 1'b1, 1'b0, 1'b0, 2'd0, W3, 5'd0,  1'b0, 8'h00, 24'hAABBCC},
    '{1'b0, 3'd5, 1'b0, 1'b0, 1'b0, 2'd0, W4, 5'd0,  1'b0, 8'h00, 24'h112233},
    '{1'b0, 3'd5, 1'b0, 1'b1, 1'b0, 2'd0, W4, 5'd0,  1'b0, 8'h00, 24'h003322}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic offer(input logic [2:0] m, input logic bg, input logic bb,
                       input logic bp, input logic [1:0] mx, input logic [31:0] w);
    @(negedge clk);
    mode_i = m; bgr_i = bg; be_byte_i = bb; be_pix_i = bp; mux_i = mx; word_i = w;
    word_valid_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    word_valid_i = 1'b0;
  endtask

  task automatic drain();
    while (!rdy_b) @(negedge clk);
  endtask

  initial begin
    #800000;
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int cnt;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 ready", {31'b0, rdy_b}, 32'd1);
    check("R1 valid", {31'b0, pv_b}, 32'd0);
    check("R1 pixel", {8'b0, rgb_b}, {24'b0, idx_b} & 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    // R3 R4 R5 R6 R7 R8 R9 R10 R11 vector walk
    for (int i = 0; i < NV; i++) begin
      offer(V[i].mode, V[i].bgr, V[i].beb, V[i].bep, V[i].mux, V[i].w);
      for (int k = 0; k < int'(V[i].n); k++) @(negedge clk);
      if (V[i].ext) begin
        check($sformatf("R8-R11 vec%0d valid", i), {31'b0, pv_x}, 32'd1);
        check($sformatf("R8-R11 vec%0d isidx", i), {31'b0, ix_x}, {31'b0, V[i].isx});
        check($sformatf("R8-R11 vec%0d index", i), {24'b0, idx_x}, {24'b0, V[i].idx});
        check($sformatf("R8-R11 vec%0d rgb", i), {8'b0, rgb_x}, {8'b0, V[i].rgb});
      end else begin
        check($sformatf("R3-R10 vec%0d valid", i), {31'b0, pv_b}, 32'd1);
        check($sformatf("R3-R10 vec%0d isidx", i), {31'b0, ix_b}, {31'b0, V[i].isx});
        check($sformatf("R3-R10 vec%0d index", i), {24'b0, idx_b}, {24'b0, V[i].idx});
        check($sformatf("R3-R10 vec%0d rgb", i), {8'b0, rgb_b}, {8'b0, V[i].rgb});
      end
      drain();
    end

    // R2 handshake: 32 pixels at mode 0, ready low throughout
    offer(3'd0, 1'b0, 1'b0, 1'b0, 2'd0, W1);
    cnt = 0;
    while (pv_b && cnt < 40) begin
      if (rdy_b) check("R2 ready during emission", 32'd1, 32'd0);
      cnt++;
      @(negedge clk);
    end
    check("R2 pixel count", cnt, 32'd32);
    check("R2 ready after last", {31'b0, rdy_b}, 32'd1);

    // R2 R3 32bpp single pixel then ready
    offer(3'd5, 1'b0, 1'b0, 1'b0, 2'd0, W4);
    check("R2 32bpp busy", {31'b0, rdy_b}, 32'd0);
    @(negedge clk);
    check("R3 32bpp ready next", {31'b0, rdy_b}, 32'd1);

    // R13 controls captured at acceptance
    offer(3'd3, 1'b0, 1'b0, 1'b0, 2'd0, W1);
    mode_i = 3'd0; be_byte_i = 1'b1; bgr_i = 1'b1;
    @(negedge clk);
    check("R13 captured mode", {24'b0, idx_b}, 32'h000000C3);
    check("R13 captured is_index", {31'b0, ix_b}, 32'd1);
    drain();
    be_byte_i = 1'b0; bgr_i = 1'b0;

    // R12 bytes per line for width 40
    @(negedge clk);
    line_width_i = 12'd40;
    mode_i = 3'd0; #1 check("R12 mode0", 32'(lb_b), 32'd5);
    mode_i = 3'd1; #1 check("R12 mode1", 32'(lb_b), 32'd10);
    mode_i = 3'd2; #1 check("R12 mode2", 32'(lb_b), 32'd20);
    mode_i = 3'd3; #1 check("R12 mode3", 32'(lb_b), 32'd40);
    mode_i = 3'd4; #1 check("R12 mode4", 32'(lb_b), 32'd80);
    mode_i = 3'd5; #1 check("R12 mode5", 32'(lb_b), 32'd160);
    mode_i = 3'd6; #1 check("R12 mode6", 32'(lb_x), 32'd80);
    mode_i = 3'd7; #1 check("R12 mode7", 32'(lb_b), 32'd80);
    line_width_i = 12'd4095; mode_i = 3'd5;
    #1 check("R12 max width", 32'(lb_b), 32'd16380);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule